// File: doc/BRIEF.md
# Serial SRAM Burst Reader

This block is the host-side serial master that pulls a run of consecutive bytes out of an external serial SRAM. The host hands over a start address, a byte count and a bus width on a request interface. The block lowers chip select and sends the read command and a 24-bit address. It then waits the number of dummy clocks that the chosen width needs, shifts the data in, and hands each finished byte to a valid/ready output stream along with the memory address it came from. The serial clock comes from a divider on the system clock.

The output stream follows the usual rules. A byte is transferred on a clock edge where `out_valid` and `out_ready` are both high. Once `out_valid` is raised, it stays high and `out_data` / `out_addr` stay unchanged until that transfer happens. The block never drops a byte. If the held byte has not been taken when the next byte is about to complete, the serial clock is parked low until the stream drains. The request side accepts a request only while the block is idle.

Top module: `sram_burst_reader`

## Requirements
- R1: `cs_n` goes low on the edge that accepts a request with a non-zero count and returns high only after the last requested byte has been clocked in. There is exactly one low period per burst. `busy` is high from acceptance until `cs_n` is high again, and `req_ready` is high only while `busy` is low.
- R2: The header is shifted MSB first: the command byte 0x03, then a 24-bit address whose top 7 bits are zero and whose low 17 bits are the requested start address. Header bits change only while `sclk` is low, so the memory samples them on rising `sclk` edges.
- R3: `req_mode` selects the lane count. 0 is one lane (header on `sio_out[0]`, data on `sio_in[0]`). 1 is two lanes (bits [1:0]). 2 is four lanes (bits [3:0]). On multi-lane transfers the highest lane carries the most significant bit of each group. The value 3 behaves as 0.
- R4: No dummy clocks follow the header with one lane, 4 follow it with two lanes and 2 with four lanes. The total number of rising `sclk` edges in a burst is therefore 32/lanes + dummies + count×8/lanes.
- R5: Data lanes are sampled on each rising `sclk` edge after the dummies and packed MSB first. Each completed byte is offered once on the output stream, so a burst of count N yields exactly N transfers.
- R6: The n-th byte of a burst comes from (start + n) modulo 2^17, and `out_addr` reports that address. Address 0x1FFFF is followed by 0x00000.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_addr` hold steady. `sclk` rises no further once the next rise would complete another byte, and it stays low until the held byte is taken.
- R8: A request with a count of zero is accepted, leaves `cs_n` high and `busy` low, and the block stays ready.
- R9: `sclk` idles low, is low whenever `cs_n` is high, and each half period lasts DIV system clocks (DIV = 2 by default, so one rise every 4 clocks in an unstalled burst).
- R10: After reset `cs_n` is high, `sclk` low, `busy` low, `out_valid` low and `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Number of bytes to read |
| req_mode | input | 2 | Lane count select (0 one, 1 two, 2 four) |
| busy | output | 1 | Burst in progress |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Memory chip select, active low |
| sio_out | output | 4 | Header lanes to the memory |
| sio_oe | output | 4 | Per-lane drive enable for sio_out |
| sio_in | input | 4 | Data lanes from the memory |
| out_valid | output | 1 | Byte available on the stream |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Received byte |
| out_addr | output | ADDR_W | Memory address of out_data |

## Verification
A header or dummy counter that is off by one shifts the sampling window by at least one lane group. That corrupts the very first byte, and the total rise count at `cs_n` release is also wrong. An address tracker that does not wrap shows up on the first byte handed out after 0x1FFFF, as a wrong `out_addr`. A hold that misjudges the stall shows up within one serial clock period, either as a change to a byte that has not been accepted or as a short transfer count at the end of the burst.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [1:0] {BUS_X1 = 2'd0, BUS_X2 = 2'd1, BUS_X4 = 2'd2, BUS_RSVD = 2'd3} bus_mode_e;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DUMMY, ST_DATA, ST_TAIL} rd_state_e;

  localparam logic [7:0] RD_CMD = 8'h03;

  function automatic bus_mode_e norm_mode(input logic [1:0] m);
    return (m == 2'd3) ? BUS_X1 : bus_mode_e'(m);
  endfunction

  function automatic logic [5:0] hdr_clocks(input bus_mode_e m);
    case (m)
      BUS_X2:  return 6'd16;
      BUS_X4:  return 6'd8;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [5:0] dummy_clocks(input bus_mode_e m);
    case (m)
      BUS_X2:  return 6'd4;
      BUS_X4:  return 6'd2;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [3:0] beats_per_byte(input bus_mode_e m);
    case (m)
      BUS_X2:  return 4'd4;
      BUS_X4:  return 4'd2;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input bus_mode_e m);
    case (m)
      BUS_X2:  return 4'b0011;
      BUS_X4:  return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction
endpackage

// File: rtl/srd_sclk_gen.sv
module srd_sclk_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic sclk,
  output logic rise_t,
  output logic fall_t
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap   = (cnt == CW'(DIV - 1));
  assign rise_t = run & ~hold & wrap & ~sclk;
  assign fall_t = run & ~hold & wrap & sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!hold) begin
      if (wrap) begin
        cnt  <= '0;
        sclk <= ~sclk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srd_hdr_tx.sv
module srd_hdr_tx
  import srd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              shift,
  input  bus_mode_e         mode,
  output logic [3:0]        lanes_out
);
  logic [31:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (load) begin
      sr <= {RD_CMD, 24'(addr)};
    end else if (shift) begin
      case (mode)
        BUS_X2:  sr <= 32'({sr, 2'b00});
        BUS_X4:  sr <= 32'({sr, 4'b0000});
        default: sr <= 32'({sr, 1'b0});
      endcase
    end
  end

  always_comb begin
    case (mode)
      BUS_X2:  lanes_out = {2'b00, sr[31:30]};
      BUS_X4:  lanes_out = sr[31:28];
      default: lanes_out = {3'b000, sr[31]};
    endcase
  end
endmodule

// File: rtl/srd_rx_pack.sv
module srd_rx_pack
  import srd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sample,
  input  bus_mode_e  mode,
  input  logic [3:0] lanes_in,
  output logic [7:0] byte_nxt,
  output logic       last_beat
);
  logic [7:0] sr;
  logic [2:0] beat;

  assign last_beat = ({1'b0, beat} == beats_per_byte(mode) - 4'd1);

  always_comb begin
    case (mode)
      BUS_X2:  byte_nxt = 8'({sr, lanes_in[1:0]});
      BUS_X4:  byte_nxt = 8'({sr, lanes_in});
      default: byte_nxt = 8'({sr, lanes_in[0]});
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      beat <= '0;
    end else if (clear) begin
      sr   <= '0;
      beat <= '0;
    end else if (sample) begin
      sr   <= byte_nxt;
      beat <= last_beat ? 3'd0 : beat + 3'd1;
    end
  end
endmodule

// File: rtl/sram_burst_reader.sv
module sram_burst_reader
  import srd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LEN_W  = 16,
  parameter int DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_mode,
  output logic              busy,
  output logic              sclk,
  output logic              cs_n,
  output logic [3:0]        sio_out,
  output logic [3:0]        sio_oe,
  input  logic [3:0]        sio_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic [ADDR_W-1:0] out_addr
);
  rd_state_e         state;
  bus_mode_e         mode_q;
  bus_mode_e         tx_mode;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [5:0]        cnt;
  logic              accept, run, hold, rise_t, fall_t, last_beat;
  logic [7:0]        rx_byte;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = req_ready & req_valid;
  assign run       = busy;
  assign hold      = (state == ST_DATA) & out_valid & ~out_ready & last_beat & ~sclk;
  assign sio_oe    = (state == ST_HDR) ? lane_mask(mode_q) : 4'b0000;
  assign tx_mode   = accept ? norm_mode(req_mode) : mode_q;

  srd_sclk_gen #(.DIV(DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(hold),
    .sclk(sclk), .rise_t(rise_t), .fall_t(fall_t)
  );

  srd_hdr_tx #(.ADDR_W(ADDR_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .load(accept), .addr(req_addr),
    .shift(fall_t && state == ST_HDR), .mode(tx_mode), .lanes_out(sio_out)
  );

  srd_rx_pack u_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .sample(rise_t && state == ST_DATA), .mode(mode_q), .lanes_in(sio_in),
    .byte_nxt(rx_byte), .last_beat(last_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mode_q    <= BUS_X1;
      cs_n      <= 1'b1;
      cur_addr  <= '0;
      remain    <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_len != '0) begin
            state    <= ST_HDR;
            mode_q   <= norm_mode(req_mode);
            cs_n     <= 1'b0;
            cur_addr <= req_addr;
            remain   <= req_len;
            cnt      <= '0;
          end
        end
        ST_HDR: begin
          if (rise_t) begin
            if (cnt == hdr_clocks(mode_q) - 6'd1) begin
              cnt   <= '0;
              state <= (dummy_clocks(mode_q) == 6'd0) ? ST_DATA : ST_DUMMY;
            end else begin
              cnt <= cnt + 6'd1;
            end
          end
        end
        ST_DUMMY: begin
          if (rise_t) begin
            if (cnt == dummy_clocks(mode_q) - 6'd1) begin
              cnt   <= '0;
              state <= ST_DATA;
            end else begin
              cnt <= cnt + 6'd1;
            end
          end
        end
        ST_DATA: begin
          if (rise_t && last_beat) begin
            out_data  <= rx_byte;
            out_valid <= 1'b1;
            out_addr  <= cur_addr;
            cur_addr  <= cur_addr + 1'b1;
            remain    <= remain - 1'b1;
            if (remain == LEN_W'(1)) state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (fall_t) begin
            state <= ST_IDLE;
            cs_n  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              sclk,
  input logic              cs_n,
  input logic [3:0]        sio_oe,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic [ADDR_W-1:0] out_addr
);
  a_r1_select_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  a_r9_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r2_drive_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe != 4'b0000) |-> !cs_n);

  a_r7_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));
endmodule

bind sram_burst_reader srd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .sclk(sclk), .cs_n(cs_n), .sio_oe(sio_oe),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_addr(out_addr)
);

// File: tb/sram_burst_reader_test.sv
`timescale 1ns/1ps
module sram_burst_reader_test;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [1:0]  req_mode = '0;
  logic        busy, sclk, cs_n;
  logic [3:0]  sio_out, sio_oe;
  logic [3:0]  sio_in = 4'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [16:0] out_addr;

  sram_burst_reader #(.ADDR_W(17), .LEN_W(16), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_mode(req_mode), .busy(busy),
    .sclk(sclk), .cs_n(cs_n), .sio_out(sio_out), .sio_oe(sio_oe), .sio_in(sio_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_addr(out_addr)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [16:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[16], 7'h15};
  endfunction

  // memory model: header capture, dummy wait, data drive
  int          dev_lanes = 1;
  int          dev_dummy = 0;
  logic [16:0] dev_start = '0;
  int          rise_n = 0;
  int          cs_falls = 0;
  logic [31:0] hdr_sr = '0;

  always @(posedge sclk or negedge cs_n) begin
    if (!sclk) begin
      rise_n = 0;
      hdr_sr = '0;
      cs_falls++;
    end else if (!cs_n) begin
      if (rise_n < 32 / dev_lanes)
        hdr_sr = (hdr_sr << dev_lanes) | 32'(sio_out & 4'((1 << dev_lanes) - 1));
      rise_n++;
    end
  end

  always @(negedge sclk) begin
    int hdr, k, bpb, tmp;
    logic [16:0] a;
    hdr = 32 / dev_lanes + dev_dummy;
    if (!cs_n && rise_n >= hdr) begin
      k   = rise_n - hdr;
      bpb = 8 / dev_lanes;
      a   = dev_start + 17'(k / bpb);
      tmp = int'(pat(a)) << ((k % bpb) * dev_lanes);
      sio_in = 4'((tmp >> (8 - dev_lanes)) & ((1 << dev_lanes) - 1));
    end
  end

  // consumer readiness
  logic [15:0] lfsr = 16'hACE1;
  bit stall_en = 1'b0;
  bit force_low = 1'b0;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = force_low ? 1'b0 : (stall_en ? lfsr[0] : 1'b1);
  end

  // stream collector, sclk period monitor, watchdog
  logic [7:0]  got_d [64];
  logic [16:0] got_a [64];
  int got_n = 0;
  int cyc = 0;
  int last_rise = 0;
  int rise_gap = 0;
  logic sclk_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (out_valid && out_ready && got_n < 64) begin
      got_d[got_n] = out_data;
      got_a[got_n] = out_addr;
      got_n++;
    end
    if (sclk && !sclk_prev) begin
      rise_gap  = cyc - last_rise;
      last_rise = cyc;
    end
    sclk_prev = sclk;
    if (cyc > 150000) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  // mode, start address, count, expected total sclk rises
  localparam int NV = 7;
  localparam logic [50:0] VEC [NV] = '{
    {2'd0, 17'h00010, 16'd4, 16'd64},
    {2'd1, 17'h00A55, 16'd5, 16'd40},
    {2'd2, 17'h01234, 16'd6, 16'd22},
    {2'd0, 17'h1FFFE, 16'd4, 16'd64},
    {2'd2, 17'h1FFFF, 16'd3, 16'd16},
    {2'd1, 17'h0FF00, 16'd1, 16'd24},
    {2'd3, 17'h00777, 16'd2, 16'd48}
  };

  task automatic set_dev(input logic [1:0] m, input logic [16:0] a);
    dev_lanes = (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
    dev_dummy = (m == 2'd1) ? 4 : (m == 2'd2) ? 2 : 0;
    dev_start = a;
  endtask

  task automatic issue(input logic [1:0] m, input logic [16:0] a, input logic [15:0] n);
    @(negedge clk);
    req_mode  = m;
    req_addr  = a;
    req_len   = n;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_and_check(input logic [16:0] a, input int n, input int falls0,
                                  input int exp_rises);
    while (busy) @(negedge clk);
    while (out_valid) @(negedge clk);
    chk(cs_n == 1'b1 && req_ready, "R1", "deselect at end", cs_n, 1);
    chk(cs_falls == falls0 + 1, "R1", "one select period", cs_falls - falls0, 1);
    chk(hdr_sr == {8'h03, 7'h00, a}, "R2", "header bits", hdr_sr, {8'h03, 7'h00, a});
    chk(rise_n == exp_rises, "R4", "sclk rises in burst", rise_n, exp_rises);
    chk(got_n == n, "R5", "byte count", got_n, n);
    for (int j = 0; j < n && j < got_n; j++) begin
      logic [16:0] ea;
      ea = a + 17'(j);
      chk(got_d[j] == pat(ea), "R5", "byte value", got_d[j], pat(ea));
      chk(got_a[j] == ea, "R6", "byte address", got_a[j], ea);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1, "R10", "reset cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R10", "reset sclk", sclk, 0);
    chk(busy == 1'b0, "R10", "reset busy", busy, 0);
    chk(out_valid == 1'b0, "R10", "reset out_valid", out_valid, 0);
    chk(req_ready == 1'b1, "R10", "reset req_ready", req_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int p = 0; p < 2; p++) begin
      stall_en = (p == 1);
      for (int i = 0; i < NV; i++) begin
        logic [1:0]  m;
        logic [16:0] a;
        int n, er, f0;
        m  = VEC[i][50:49];
        a  = VEC[i][48:32];
        n  = int'(VEC[i][31:16]);
        er = int'(VEC[i][15:0]);
        set_dev(m, a);
        got_n = 0;
        f0 = cs_falls;
        issue(m, a, 16'(n));
        chk(busy && !cs_n && !req_ready, "R1", "busy after accept", {busy, cs_n, req_ready}, 3'b100);
        finish_and_check(a, n, f0, er);
        if (p == 0) chk(rise_gap == 2 * DIV, "R9", "sclk period", rise_gap, 2 * DIV);
        if (m == 2'd3) chk(got_n == n, "R3", "mode 3 acts as one lane", got_n, n);
      end
    end
    stall_en = 1'b0;

    // zero count
    begin
      int f0;
      f0 = cs_falls;
      issue(2'd0, 17'h00040, 16'd0);
      for (int t = 0; t < 20; t++) begin
        if (busy || !cs_n) begin
          chk(1'b0, "R8", "zero count activity", {busy, cs_n}, 2'b01);
          break;
        end
        @(negedge clk);
      end
      chk(cs_falls == f0, "R8", "no select on zero count", cs_falls - f0, 0);
      chk(req_ready && !busy, "R8", "ready after zero count", req_ready, 1);
    end

    // long stall on the output stream
    begin
      int f0, r0;
      logic [7:0] d0;
      set_dev(2'd0, 17'h00100);
      got_n = 0;
      f0 = cs_falls;
      force_low = 1'b1;
      @(negedge clk);
      issue(2'd0, 17'h00100, 16'd3);
      while (!out_valid) @(negedge clk);
      repeat (60) @(negedge clk);
      r0 = rise_n;
      d0 = out_data;
      repeat (40) @(negedge clk);
      chk(rise_n == r0, "R7", "sclk frozen during stall", rise_n, r0);
      chk(sclk == 1'b0, "R7", "sclk low during stall", sclk, 0);
      chk(out_valid && out_data == d0, "R7", "held byte stable", out_data, d0);
      chk(d0 == pat(17'h00100), "R5", "first held byte", d0, pat(17'h00100));
      force_low = 1'b0;
      finish_and_check(17'h00100, 3, f0, 56);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule